// File: doc/BRIEF.md
# Decimal-Mode Add/Subtract Unit

This block performs the arithmetic step of an 8-bit accumulator machine's add-with-carry and subtract-with-borrow instructions. It works in plain binary or in packed BCD. A parameter selects one of two silicon generations. The early generation leaves some flags in decimal mode as raw intermediate or binary values. The later generation gives decimal flags taken from the final byte and spends one extra clock on a decimal operation. The instruction sequencer presents the accumulator, the fetched operand, the carry flag, the decimal flag and the operation select with a one-cycle `start`. It takes the new accumulator and the N, V, Z and C flags when `done` pulses.

The results are registered. They stay on the outputs until the next operation finishes. While a slow decimal operation on the later generation is in flight, a new `start` is not accepted.

Top module: `dec_addsub`

## Requirements
- R1: A `start` sampled while the unit is idle produces a single-cycle `done` on the next clock edge, except in the case given in R2.
- R2: With `VARIANT` = late generation and `dec_mode`=1, `done` rises on the second edge after `start`. A `start` on the edge between those two is ignored and causes no extra `done`.
- R3: Binary add (`op_sub`=0, `dec_mode`=0), in both variants, gives acc = (a+b+cin) mod 256 and C = carry out of bit 7. N is acc bit 7, Z is acc==0, and V is set when a and b have equal sign bits and the acc sign differs from them.
- R4: Binary subtract (`op_sub`=1, `dec_mode`=0), in both variants, gives acc = (a-b-(1-cin)) mod 256 and C=1 when no borrow occurs. N and Z come from acc. V is set when a and b differ in sign and the acc sign differs from a.
- R5: Early decimal add forms the low digit as a_lo+b_lo+cin, plus 6 when it exceeds 9. It then adds both high nibbles, plus 0x10 when the adjusted digit exceeds 0x0F. It adds 0x60 when bits 8:4 of that sum exceed 9. acc is the low byte and C is set when the corrected sum reaches 0x100.
- R6: Early decimal add takes Z from the binary sum (a+b+cin) mod 256. It takes N from bit 7 of the uncorrected sum of R5. V is set when a and b have equal signs and bit 7 of that uncorrected sum differs from bit 7 of a.
- R7: Early decimal subtract takes C, N, Z and V exactly as in R4. acc is the digit-corrected difference. The low digit loses a further 6 on a nibble borrow, with a borrow of 0x10 from the high part. 0x60 is subtracted when bit 8 of the combined value is set.
- R8: Late decimal add maps a low digit sum (a_lo+b_lo+cin) of 10 or more to 0x10|((d+6)&0xF) and adds both high nibbles. A total of 0xA0 or more sets C and adds 0x60; a smaller total clears C. N and Z come from acc. V starts as "equal signs" and is cleared if the pre-correction total is at least 0x180 (carry) or below 0x80 (no carry).
- R9: Late decimal subtract forms the low digit as 0x0F+a_lo-b_lo+cin. Below 0x10 it subtracts 6 and gives no high carry; otherwise it subtracts 0x10 and gives a high carry of 0x10. The high part 0xF0+a_hi-b_hi+carry below 0x100 clears C and subtracts 0x60, otherwise C is set. acc = high part + low digit (mod 256). N and Z come from acc. V starts as "different signs" and is cleared by the thresholds of R8 applied to the high part.
- R10: Reset clears acc and all flags to 0 and `done` to 0. Between `done` pulses the outputs do not change, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to perform an operation |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_mode | input | 1 | 1 = packed BCD arithmetic |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Operand |
| carry_in | input | 1 | Current carry flag |
| acc_out | output | 8 | New accumulator |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| done | output | 1 | Result valid pulse |

## Verification
The hardest results to reach are the decimal outcomes on bytes that are not valid BCD. Those are where the early generation's intermediate-value flags and the late generation's thresholds give visibly different bytes and flags. The stimulus therefore covers all 100×100 valid BCD operand pairs with both carry values and both operations. It then runs every accumulator byte against a strided set of operand bytes that includes illegal digits, in both binary and decimal mode. Both variants are instantiated side by side on the same stimulus and checked against a reference model in the bench. A directed sequence raises `start` again during the late generation's extra decimal cycle, to show that the second request is ignored.

// File: rtl/dec_addsub_pkg.sv
package dec_addsub_pkg;
   localparam int BYTE_W = 8;
   localparam int NIB_W  = BYTE_W / 2;

   typedef enum logic {
      VAR_EARLY = 1'b0,
      VAR_LATE  = 1'b1
   } variant_e;

   typedef struct packed {
      logic [BYTE_W-1:0] acc;
      logic              n;
      logic              v;
      logic              z;
      logic              c;
   } alu_res_t;
endpackage

// File: rtl/early_addsub_core.sv
module early_addsub_core
   import dec_addsub_pkg::*;
(
   input  logic [7:0] a,
   input  logic [7:0] b,
   input  logic       cin,
   input  logic       sub,
   input  logic       dec,
   output alu_res_t   res
);
   logic [8:0] bsum;
   logic [8:0] bdiff;
   logic [5:0] lo_add;
   logic [8:0] mid_pre;
   logic [9:0] mid_fix;
   logic [4:0] lo_sub;
   logic [8:0] hi_sub;
   logic [8:0] dsub;

   assign bsum  = {1'b0, a} + {1'b0, b} + {8'd0, cin};
   assign bdiff = {1'b0, a} - {1'b0, b} - {8'd0, ~cin};

   // decimal add path: digit adjust then high-digit adjust
   always_comb begin
      lo_add = {2'd0, a[3:0]} + {2'd0, b[3:0]} + {5'd0, cin};
      if (lo_add > 6'd9)
         lo_add = lo_add + 6'd6;
      mid_pre = {5'd0, lo_add[3:0]} + {1'b0, a[7:4], 4'd0} + {1'b0, b[7:4], 4'd0}
              + ((lo_add > 6'd15) ? 9'h010 : 9'h000);
      mid_fix = (mid_pre[8:4] > 5'd9) ? ({1'b0, mid_pre} + 10'h060) : {1'b0, mid_pre};
   end

   // decimal subtract path: accumulator only, flags stay binary
   always_comb begin
      lo_sub = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'd0, ~cin};
      hi_sub = {1'b0, a[7:4], 4'd0} - {1'b0, b[7:4], 4'd0};
      if (lo_sub[4])
         dsub = {5'd0, lo_sub[3:0] - 4'd6} | (hi_sub - 9'h010);
      else
         dsub = {5'd0, lo_sub[3:0]} | hi_sub;
      if (dsub[8])
         dsub = dsub - 9'h060;
   end

   always_comb begin
      if (!sub && !dec) begin
         res.acc = bsum[7:0];
         res.c   = bsum[8];
         res.n   = bsum[7];
         res.z   = (bsum[7:0] == 8'd0);
         res.v   = (a[7] == b[7]) && (a[7] != bsum[7]);
      end else if (!sub) begin
         res.acc = mid_fix[7:0];
         res.c   = (mid_fix[9:8] != 2'd0);
         res.n   = mid_pre[7];
         res.z   = (bsum[7:0] == 8'd0);
         res.v   = (a[7] ^ mid_pre[7]) & ~(a[7] ^ b[7]);
      end else begin
         res.acc = dec ? dsub[7:0] : bdiff[7:0];
         res.c   = ~bdiff[8];
         res.n   = bdiff[7];
         res.z   = (bdiff[7:0] == 8'd0);
         res.v   = (a[7] ^ bdiff[7]) & (a[7] ^ b[7]);
      end
   end
endmodule

// File: rtl/late_addsub_core.sv
module late_addsub_core
   import dec_addsub_pkg::*;
(
   input  logic [7:0] a,
   input  logic [7:0] b,
   input  logic       cin,
   input  logic       sub,
   input  logic       dec,
   output alu_res_t   res
);
   logic [4:0] lo_a;
   logic [4:0] lo_a2;
   logic [8:0] sum;
   logic       add_c;
   logic       add_v;
   logic [7:0] add_out;

   logic [4:0] lo_s;
   logic       hc;
   logic [7:0] lo_fix;
   logic [8:0] diff;
   logic       sub_c;
   logic       sub_v;
   logic [7:0] sub_out;

   logic [7:0] acc;

   // add
   always_comb begin
      lo_a  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, cin};
      lo_a2 = (lo_a >= 5'd10) ? {1'b1, lo_a[3:0] + 4'd6} : lo_a;
      if (dec)
         sum = {4'd0, lo_a2} + {1'b0, a[7:4], 4'd0} + {1'b0, b[7:4], 4'd0};
      else
         sum = {1'b0, a} + {1'b0, b} + {8'd0, cin};
      add_c   = dec ? (sum >= 9'h0A0) : sum[8];
      add_v   = ~(a[7] ^ b[7]) & (add_c ? (sum < 9'h180) : (sum >= 9'h080));
      add_out = sum[7:0] + ((add_c && dec) ? 8'h60 : 8'h00);
   end

   // subtract
   always_comb begin
      lo_s   = 5'h0F + {1'b0, a[3:0]} - {1'b0, b[3:0]} + {4'd0, cin};
      hc     = (lo_s >= 5'h10);
      lo_fix = {3'd0, lo_s} - (hc ? 8'h10 : 8'h06);
      if (dec)
         diff = 9'h0F0 + {1'b0, a[7:4], 4'd0} - {1'b0, b[7:4], 4'd0} + (hc ? 9'h010 : 9'h000);
      else
         diff = 9'h0FF + {1'b0, a} - {1'b0, b} + {8'd0, cin};
      sub_c   = diff[8];
      sub_v   = (a[7] ^ b[7]) & (sub_c ? (diff < 9'h180) : (diff >= 9'h080));
      if (dec)
         sub_out = diff[7:0] - (sub_c ? 8'h00 : 8'h60) + lo_fix;
      else
         sub_out = diff[7:0];
   end

   always_comb begin
      acc     = sub ? sub_out : add_out;
      res.acc = acc;
      res.c   = sub ? sub_c : add_c;
      res.v   = sub ? sub_v : add_v;
      res.n   = acc[7];
      res.z   = (acc == 8'd0);
   end
endmodule

// File: rtl/addsub_seq.sv
module addsub_seq
   import dec_addsub_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     slow,
   input  alu_res_t res_in,
   output alu_res_t res_out,
   output logic     busy,
   output logic     done
);
   alu_res_t stage_q;
   alu_res_t out_q;
   logic     busy_q;
   logic     done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= '0;
         out_q   <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            busy_q <= 1'b0;
            out_q  <= stage_q;
            done_q <= 1'b1;
         end else if (start) begin
            if (slow) begin
               busy_q  <= 1'b1;
               stage_q <= res_in;
            end else begin
               out_q  <= res_in;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign res_out = out_q;
   assign busy    = busy_q;
   assign done    = done_q;

   p_fast_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_q && !slow) |=> done_q);

   p_slow_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_q && slow) |=> (!done_q ##1 done_q));

   p_busy_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> !busy_q);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_q) |-> done_q);
endmodule

// File: rtl/dec_addsub.sv
module dec_addsub
   import dec_addsub_pkg::*;
#(
   parameter int       DATA_W  = 8,
   parameter variant_e VARIANT = VAR_LATE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_sub,
   input  logic              dec_mode,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] opnd_in,
   input  logic              carry_in,
   output logic [DATA_W-1:0] acc_out,
   output logic              flag_n,
   output logic              flag_v,
   output logic              flag_z,
   output logic              flag_c,
   output logic              done
);
   localparam bit EXTRA_DEC_CYCLE = (VARIANT == VAR_LATE);

   alu_res_t core_res;
   alu_res_t held;
   logic     slow;
   logic     busy;

   if (DATA_W != BYTE_W) begin : g_width_check
      $error("dec_addsub: DATA_W must equal %0d", BYTE_W);
   end

   if (VARIANT == VAR_LATE) begin : g_late
      late_addsub_core u_core (
         .a   (acc_in),
         .b   (opnd_in),
         .cin (carry_in),
         .sub (op_sub),
         .dec (dec_mode),
         .res (core_res)
      );
   end else begin : g_early
      early_addsub_core u_core (
         .a   (acc_in),
         .b   (opnd_in),
         .cin (carry_in),
         .sub (op_sub),
         .dec (dec_mode),
         .res (core_res)
      );
   end

   assign slow = EXTRA_DEC_CYCLE && dec_mode;

   addsub_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .slow    (slow),
      .res_in  (core_res),
      .res_out (held),
      .busy    (busy),
      .done    (done)
   );

   assign acc_out = held.acc;
   assign flag_n  = held.n;
   assign flag_v  = held.v;
   assign flag_z  = held.z;
   assign flag_c  = held.c;

   p_bin_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !dec_mode && !op_sub) |=>
      ({flag_c, acc_out} == $past({1'b0, acc_in} + {1'b0, opnd_in} + {8'd0, carry_in})));

   p_bin_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !dec_mode && op_sub) |=>
      (acc_out == $past(acc_in - opnd_in - {7'd0, ~carry_in})));
endmodule

// File: tb/sim_dec_addsub.sv
`timescale 1ns/1ps
module sim_dec_addsub;
   import dec_addsub_pkg::*;

   localparam int WATCHDOG = 198000;

   typedef struct {
      logic [11:0] exp;
      int          cyc;
      string       tag;
      string       ttag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic op_sub = 1'b0;
   logic dec_mode = 1'b0;
   logic [7:0] acc_in = 8'd0;
   logic [7:0] opnd_in = 8'd0;
   logic carry_in = 1'b0;

   logic [7:0] l_acc, e_acc;
   logic l_n, l_v, l_z, l_c, l_done;
   logic e_n, e_v, e_z, e_c, e_done;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   item_t q_late[$];
   item_t q_early[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dec_addsub #(.DATA_W(8), .VARIANT(VAR_LATE)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub), .dec_mode(dec_mode),
      .acc_in(acc_in), .opnd_in(opnd_in), .carry_in(carry_in),
      .acc_out(l_acc), .flag_n(l_n), .flag_v(l_v), .flag_z(l_z), .flag_c(l_c), .done(l_done));

   dec_addsub #(.DATA_W(8), .VARIANT(VAR_EARLY)) u1 (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub), .dec_mode(dec_mode),
      .acc_in(acc_in), .opnd_in(opnd_in), .carry_in(carry_in),
      .acc_out(e_acc), .flag_n(e_n), .flag_v(e_v), .flag_z(e_z), .flag_c(e_c), .done(e_done));

   function automatic logic [11:0] pack(int acc, bit n, bit v, bit z, bit c);
      logic [7:0] a8;
      a8 = acc[7:0];
      return {a8, n, v, z, c};
   endfunction

   // binary reference shared by both generations (R3, R4)
   function automatic logic [11:0] ref_bin(bit sub, int a, int b, int c);
      int r, res8;
      bit cy, v;
      if (!sub) begin
         r  = a + b + c;
         cy = (r > 255);
      end else begin
         r  = a - b - (1 - c);
         cy = (r >= 0);
      end
      res8 = r & 255;
      if (!sub) v = ((a >= 128) == (b >= 128)) && ((res8 >= 128) != (a >= 128));
      else      v = ((a >= 128) != (b >= 128)) && ((res8 >= 128) != (a >= 128));
      return pack(res8, res8 >= 128, v, res8 == 0, cy);
   endfunction

   function automatic logic [11:0] ref_early(bit sub, bit dec, int a, int b, int c);
      int lo, m, pre, t2;
      logic [11:0] bin;
      bin = ref_bin(sub, a, b, c);
      if (!dec) return bin;
      if (!sub) begin
         lo = (a % 16) + (b % 16) + c;
         if (lo > 9) lo = lo + 6;
         m = (lo % 16) + (a / 16) * 16 + (b / 16) * 16 + ((lo > 15) ? 16 : 0);
         pre = m;
         if (((m / 16) % 32) > 9) m = m + 96;
         return pack(m & 255, ((pre / 128) % 2) == 1,
                     (((pre / 128) % 2) != (a / 128)) && ((a / 128) == (b / 128)),
                     ((a + b + c) % 256) == 0, m >= 256);
      end
      t2 = (a % 16) - (b % 16) - (1 - c);
      if (t2 < 0) m = ((t2 - 6) & 15) + ((a / 16) - (b / 16) - 1) * 16;
      else        m = t2 + ((a / 16) - (b / 16)) * 16;
      if (m < 0) m = m - 96;
      return {m[7:0], bin[3:0]};
   endfunction

   function automatic logic [11:0] ref_late(bit sub, bit dec, int a, int b, int c);
      int lo, s, h, res8;
      bit cy, v;
      if (!dec) return ref_bin(sub, a, b, c);
      if (!sub) begin
         lo = (a % 16) + (b % 16) + c;
         if (lo >= 10) lo = 16 + ((lo + 6) % 16);
         s  = lo + (a / 16) * 16 + (b / 16) * 16;
         cy = (s >= 160);
         v  = ((a / 128) == (b / 128)) && (cy ? (s < 384) : (s >= 128));
         if (cy) s = s + 96;
      end else begin
         lo = 15 + (a % 16) - (b % 16) + c;
         h  = 240 + (a / 16) * 16 - (b / 16) * 16;
         if (lo < 16) lo = lo - 6;
         else begin lo = lo - 16; h = h + 16; end
         cy = (h >= 256);
         v  = ((a / 128) != (b / 128)) && (cy ? (h < 384) : (h >= 128));
         if (!cy) h = h - 96;
         s  = h + lo;
      end
      res8 = s & 255;
      return pack(res8, res8 >= 128, v, res8 == 0, cy);
   endfunction

   function automatic string tag_of(bit early, bit sub, bit dec);
      if (!dec) return sub ? "R4" : "R3";
      if (early) return sub ? "R7" : "R5/R6";
      return sub ? "R9" : "R8";
   endfunction

   task automatic report_fail(string tag, string what, logic [11:0] act, logic [11:0] exp);
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (acc,n,v,z,c)", tag, what, act, exp);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // driver: one operation, leaves start raised on the fast path
   task automatic issue(bit sub, bit dec, int a, int b, int c);
      item_t il, ie;
      @(negedge clk);
      op_sub = sub; dec_mode = dec; acc_in = a[7:0]; opnd_in = b[7:0]; carry_in = c[0];
      start = 1'b1;
      il.exp = ref_late(sub, dec, a, b, c);
      il.cyc = cyc + 1 + (dec ? 1 : 0);
      il.tag = tag_of(1'b0, sub, dec);
      il.ttag = dec ? "R2" : "R1";
      ie.exp = ref_early(sub, dec, a, b, c);
      ie.cyc = cyc + 1;
      ie.tag = tag_of(1'b1, sub, dec);
      ie.ttag = "R1";
      q_late.push_back(il);
      q_early.push_back(ie);
      if (dec) begin
         @(negedge clk);
         start = 1'b0;
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         start = 1'b0;
      end
   endtask

   // monitor: pops and compares as results appear
   always @(negedge clk) begin
      if (rst_n && l_done) begin
         if (q_late.size() == 0) begin
            checks++;
            report_fail("R2", "late: unexpected done", {l_acc, l_n, l_v, l_z, l_c}, 12'h000);
         end else begin
            item_t it;
            it = q_late.pop_front();
            checks += 2;
            if ({l_acc, l_n, l_v, l_z, l_c} !== it.exp)
               report_fail(it.tag, "late result", {l_acc, l_n, l_v, l_z, l_c}, it.exp);
            if (cyc != it.cyc) begin
               errors++;
               $display("FAIL %s late done timing actual=%0d expected=%0d", it.ttag, cyc, it.cyc);
            end
         end
      end
      if (rst_n && e_done) begin
         if (q_early.size() == 0) begin
            checks++;
            report_fail("R1", "early: unexpected done", {e_acc, e_n, e_v, e_z, e_c}, 12'h000);
         end else begin
            item_t it;
            it = q_early.pop_front();
            checks += 2;
            if ({e_acc, e_n, e_v, e_z, e_c} !== it.exp)
               report_fail(it.tag, "early result", {e_acc, e_n, e_v, e_z, e_c}, it.exp);
            if (cyc != it.cyc) begin
               errors++;
               $display("FAIL %s early done timing actual=%0d expected=%0d", it.ttag, cyc, it.cyc);
            end
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > WATCHDOG && !finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         finish_run();
      end
   end

   initial begin
      logic [11:0] last;
      item_t il, ie;
      repeat (4) @(negedge clk);
      // R10: reset state
      checks++;
      if ({l_acc, l_n, l_v, l_z, l_c, l_done, e_acc, e_n, e_v, e_z, e_c, e_done} !== 26'd0)
         report_fail("R10", "reset state", {l_acc, l_n, l_v, l_z, l_c}, 12'h000);
      rst_n = 1'b1;
      idle(2);

      // R2: second start during the extra decimal cycle is ignored by the late variant
      @(negedge clk);
      op_sub = 1'b0; dec_mode = 1'b1; acc_in = 8'h15; opnd_in = 8'h27; carry_in = 1'b0;
      start = 1'b1;
      il.exp = ref_late(0, 1, 'h15, 'h27, 0); il.cyc = cyc + 2; il.tag = "R8"; il.ttag = "R2";
      ie.exp = ref_early(0, 1, 'h15, 'h27, 0); ie.cyc = cyc + 1; ie.tag = "R5/R6"; ie.ttag = "R1";
      q_late.push_back(il); q_early.push_back(ie);
      @(negedge clk);
      acc_in = 8'h33; opnd_in = 8'h44; carry_in = 1'b1;
      ie.exp = ref_early(0, 1, 'h33, 'h44, 1); ie.cyc = cyc + 1;
      q_early.push_back(ie);
      idle(4);
      checks++;
      if (q_late.size() != 0 || l_acc !== 8'h42)
         report_fail("R2", "busy start accepted", {l_acc, 4'h0}, {8'h42, 4'h0});

      // R10: outputs hold while inputs move without start
      issue(1, 0, 'h80, 'h01, 1);
      idle(2);
      last = {l_acc, l_n, l_v, l_z, l_c};
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         acc_in = 8'(i * 37); opnd_in = 8'(i * 11); op_sub = i[0]; dec_mode = i[1];
      end
      checks++;
      if ({l_acc, l_n, l_v, l_z, l_c} !== last || last !== ref_bin(1, 'h80, 'h01, 1))
         report_fail("R10", "hold between dones", {l_acc, l_n, l_v, l_z, l_c}, last);

      // all valid BCD pairs, both carries, both operations (R5-R9)
      for (int a = 0; a < 100; a++)
         for (int b = 0; b < 100; b++)
            for (int k = 0; k < 4; k++)
               issue(k[1], 1, (a / 10) * 16 + (a % 10), (b / 10) * 16 + (b % 10), k % 2);
      idle(3);

      // binary sweep: every accumulator byte, strided operands (R1, R3, R4)
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b += 5)
            for (int k = 0; k < 4; k++)
               issue(k[1], 0, a, b, k % 2);
      idle(3);

      // decimal on illegal digits (R5-R9)
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b += 17)
            for (int k = 0; k < 4; k++)
               issue(k[1], 1, a, b, k % 2);
      idle(4);

      checks++;
      if (q_late.size() != 0 || q_early.size() != 0)
         report_fail("R1", "missing done", 12'(q_late.size()), 12'(q_early.size()));
      finish_run();
   end
endmodule